// File: doc/BRIEF.md
# Video Timing and Subcarrier Reset Controller

This block keeps the raster timing of a standard-definition encoder. It holds a pixel counter, a line counter and a field index. It also keeps a 32-bit colour-subcarrier phase accumulator, which adds a frequency word on every clock. A separate pixel/line counter pair serves the high-definition path and can be frozen by a single control input.

One external pin, `sync_pin`, is shared by four behaviours, and a 2-bit mode input picks one of them. The pin can be ignored. Its rising edge can freeze the raster counters and its falling edge restart them, which also clears the phase. A rising edge can arm a phase clear that lands on the next field boundary. Finally, the pin can carry a framed serial word that holds a new subcarrier frequency. The block applies that word on the next line boundary.

The pin passes through a two-flop synchroniser and an edge detector before any of these behaviours uses it. After the active-low reset input is released, an internal two-flop reset synchroniser lets the block start counting.

Top module: `video_sync_ctrl`

## Requirements
- R1: While reset is asserted, every counter, the field index, the phase and the frequency output read zero.
- R2: The SD pixel counter runs from 0 to H_TOTAL-1 and then wraps to 0. The line counter advances on that wrap and itself wraps after V_TOTAL-1. The field index (0 meaning the first field) advances on the last pixel of the last line.
- R3: The field index wraps from 7 to 0 when `pal_mode`=1 and from 3 to 0 when `pal_mode`=0.
- R4: With `sync_mode`=2'b00 the pin has no effect: counters and phase keep running unchanged through any pulse.
- R5: With `sync_mode`=2'b10, a rising edge on the synchronised pin holds pixel, line and field at 0 for as long as the pin stays high.
- R6: With `sync_mode`=2'b10, when the pin falls, the phase and all raster counters read 0 after the third clock edge following the fall, and counting resumes from there.
- R7: With `sync_mode`=2'b01, a rising edge makes the phase read 0 in the first cycle of the next field (pixel 0, line 0). The field index still advances normally and is not reset.
- R8: On every clock that applies no clear, the phase accumulator adds `sc_freq` modulo 2^32.
- R9: Whenever `sync_mode` is not 2'b11, `sc_freq` follows `cfg_freq` with one clock of latency.
- R10: With `sync_mode`=2'b11, a frame on the pin is sent as follows, with each bit lasting two clocks: one high start bit, then 67 data bits, least significant first. Data bits 0..21 form the new frequency, which appears on `sc_freq` zero-extended. Bits 22..66 are ignored.
- R11: A received frequency is applied only at a line boundary, so `sc_freq` changes in the same cycle that the pixel counter returns to 0.
- R12: While `hd_hold`=1, the HD pixel and line counters read 0, and the SD counters are unaffected. On the first clock after `hd_hold` drops, the HD pixel counter reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 2 | 00 ignore, 01 phase reset, 10 timing reset, 11 frequency lock |
| pal_mode | input | 1 | 1: eight-field sequence, 0: four-field sequence |
| sync_pin | input | 1 | Asynchronous external sync / serial pin |
| hd_hold | input | 1 | Holds HD counters at zero while 1 |
| cfg_freq | input | 32 | Subcarrier frequency word used outside lock mode |
| sd_h | output | 5 | SD pixel counter |
| sd_v | output | 2 | SD line counter |
| sd_field | output | 3 | Field index, 0 = first field |
| sc_phase | output | 32 | Subcarrier phase accumulator |
| sc_freq | output | 32 | Frequency word in use |
| hd_h | output | 6 | HD pixel counter |
| hd_v | output | 3 | HD line counter |

## Verification
The bench checks the fall of the timing-reset pin cycle by cycle. If a design cleared the phase on the rise, or restarted one clock early or late, it would show a nonzero phase or a wrong pixel count three edges after the fall. The phase-reset case checks the next field start for both a zero phase and an advanced field index. A design that reset the field counter, or cleared the phase at once, would fail one of those two checks. The serial frames carry filler ones above bit 21 and distinct low values. A receiver that slipped a bit, sampled on the wrong half of a bit or kept the upper bits would produce a wrong `sc_freq`. The bench also checks that the new word lands exactly when the pixel counter returns to 0.

// File: rtl/tvr_pkg.sv
package tvr_pkg;

  typedef enum logic [1:0] {
    SYNC_IGNORE     = 2'b00,
    SYNC_PHASE_RST  = 2'b01,
    SYNC_TIMING_RST = 2'b10,
    SYNC_FREQ_LOCK  = 2'b11
  } sync_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_START = 2'b01,
    RX_DATA  = 2'b10
  } rx_state_e;

endpackage

// File: rtl/tvr_pin_sync.sv
module tvr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall  = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/tvr_sd_counters.sv
module tvr_sd_counters #(
  parameter int H_TOTAL     = 32,
  parameter int V_TOTAL     = 4,
  parameter int FIELDS_PAL  = 8,
  parameter int FIELDS_NTSC = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           pal_mode,
  output logic [$clog2(H_TOTAL)-1:0]     h_cnt,
  output logic [$clog2(V_TOTAL)-1:0]     v_cnt,
  output logic [$clog2(FIELDS_PAL)-1:0]  field,
  output logic                           line_end,
  output logic                           field_end
);

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam int FW = $clog2(FIELDS_PAL);
  localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
  localparam logic [FW-1:0] PAL_LAST  = FW'(FIELDS_PAL - 1);
  localparam logic [FW-1:0] NTSC_LAST = FW'(FIELDS_NTSC - 1);

  logic [HW-1:0] h_q, h_n;
  logic [VW-1:0] v_q, v_n;
  logic [FW-1:0] f_q, f_n;
  logic [FW-1:0] fld_last;

  assign fld_last  = pal_mode ? PAL_LAST : NTSC_LAST;
  assign line_end  = !clr && (h_q == H_LAST);
  assign field_end = line_end && (v_q == V_LAST);

  always_comb begin
    h_n = h_q;
    v_n = v_q;
    f_n = f_q;
    if (clr) begin
      h_n = '0;
      v_n = '0;
      f_n = '0;
    end else if (h_q == H_LAST) begin
      h_n = '0;
      if (v_q == V_LAST) begin
        v_n = '0;
        f_n = (f_q >= fld_last) ? '0 : f_q + 1'b1;
      end else begin
        v_n = v_q + 1'b1;
      end
    end else begin
      h_n = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
      f_q <= '0;
    end else begin
      h_q <= h_n;
      v_q <= v_n;
      f_q <= f_n;
    end
  end

  assign h_cnt = h_q;
  assign v_cnt = v_q;
  assign field = f_q;

  // Counter ranges and wrap points
  assert_pixel_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q <= H_LAST) && (v_q <= V_LAST));

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (h_q == '0));

  assert_field_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && (f_q == fld_last)) |=> (f_q == '0));

endmodule

// File: rtl/tvr_lock_rx.sv
module tvr_lock_rx
  import tvr_pkg::*;
#(
  parameter int FRAME_BITS = 67,
  parameter int VAL_BITS   = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                pin_level,
  input  logic                pin_rise,
  output logic                word_valid,
  output logic [VAL_BITS-1:0] word
);

  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] ALL_BITS = CW'(FRAME_BITS);

  rx_state_e             st_q, st_n;
  logic                  half_q, half_n;
  logic [CW-1:0]         cnt_q, cnt_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n, sh_shift;
  logic [VAL_BITS-1:0]   word_q, word_n;
  logic                  valid_q, valid_n;
  logic                  sample_en;

  assign sh_shift  = {pin_level, sh_q[FRAME_BITS-1:1]};
  assign sample_en = enable && (st_q == RX_DATA) && half_q;

  always_comb begin
    st_n    = st_q;
    half_n  = half_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    word_n  = word_q;
    valid_n = 1'b0;
    if (!enable) begin
      st_n = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (pin_rise) st_n = RX_START;
        end
        RX_START: begin
          st_n   = RX_DATA;
          half_n = 1'b0;
          cnt_n  = '0;
        end
        RX_DATA: begin
          if (!sample_en) begin
            half_n = 1'b1;
          end else begin
            half_n = 1'b0;
            sh_n   = sh_shift;
            cnt_n  = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              word_n  = sh_shift[VAL_BITS-1:0];
              valid_n = 1'b1;
              st_n    = RX_IDLE;
            end
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      half_q  <= half_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      word_q  <= word_n;
      valid_q <= valid_n;
    end
  end

  assign word_valid = valid_q;
  assign word       = word_q;

  // Frame bit count never runs past the frame length
  assert_bit_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ALL_BITS);

  // A word is only delivered out of the data phase
  assert_word_from_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(st_q) == RX_DATA));

endmodule

// File: rtl/tvr_hd_counters.sv
module tvr_hd_counters #(
  parameter int H_TOTAL = 40,
  parameter int V_TOTAL = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold,
  output logic [$clog2(H_TOTAL)-1:0] h_cnt,
  output logic [$clog2(V_TOTAL)-1:0] v_cnt
);

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_q, h_n;
  logic [VW-1:0] v_q, v_n;

  always_comb begin
    h_n = h_q;
    v_n = v_q;
    if (hold) begin
      h_n = '0;
      v_n = '0;
    end else if (h_q == H_LAST) begin
      h_n = '0;
      v_n = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_n = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_n;
      v_q <= v_n;
    end
  end

  assign h_cnt = h_q;
  assign v_cnt = v_q;

  assert_hd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (h_q == '0 && v_q == '0));

  assert_hd_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q <= H_LAST) && (v_q <= V_LAST));

endmodule

// File: rtl/video_sync_ctrl.sv
module video_sync_ctrl
  import tvr_pkg::*;
#(
  parameter int H_TOTAL     = 32,
  parameter int V_TOTAL     = 4,
  parameter int FIELDS_PAL  = 8,
  parameter int FIELDS_NTSC = 4,
  parameter int HD_H_TOTAL  = 40,
  parameter int HD_V_TOTAL  = 6,
  parameter int PHASE_W     = 32,
  parameter int FRAME_BITS  = 67,
  parameter int FREQ_BITS   = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      sync_mode,
  input  logic                            pal_mode,
  input  logic                            sync_pin,
  input  logic                            hd_hold,
  input  logic [PHASE_W-1:0]              cfg_freq,
  output logic [$clog2(H_TOTAL)-1:0]      sd_h,
  output logic [$clog2(V_TOTAL)-1:0]      sd_v,
  output logic [$clog2(FIELDS_PAL)-1:0]   sd_field,
  output logic [PHASE_W-1:0]              sc_phase,
  output logic [PHASE_W-1:0]              sc_freq,
  output logic [$clog2(HD_H_TOTAL)-1:0]   hd_h,
  output logic [$clog2(HD_V_TOTAL)-1:0]   hd_v
);

  localparam int PAD_W = PHASE_W - FREQ_BITS;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  sync_mode_e mode;
  assign mode = sync_mode_e'(sync_mode);

  // Pin conditioning
  logic pin_level, pin_rise, pin_fall;

  tvr_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (rst_core_n),
    .pin   (sync_pin),
    .level (pin_level),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  // Mode control
  logic tr_hold_q, tr_hold_n;
  logic scr_pend_q, scr_pend_n;
  logic lock_pend_q, lock_pend_n;
  logic sd_clr, tr_release, scr_clear, lock_apply;
  logic line_end, field_end;
  logic is_tr, is_scr, is_lock;

  assign is_tr   = (mode == SYNC_TIMING_RST);
  assign is_scr  = (mode == SYNC_PHASE_RST);
  assign is_lock = (mode == SYNC_FREQ_LOCK);

  assign sd_clr     = is_tr && (tr_hold_q || pin_rise);
  assign tr_release = is_tr && tr_hold_q && pin_fall;
  assign scr_clear  = is_scr && scr_pend_q && field_end;

  tvr_sd_counters #(
    .H_TOTAL     (H_TOTAL),
    .V_TOTAL     (V_TOTAL),
    .FIELDS_PAL  (FIELDS_PAL),
    .FIELDS_NTSC (FIELDS_NTSC)
  ) u_sd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (sd_clr),
    .pal_mode  (pal_mode),
    .h_cnt     (sd_h),
    .v_cnt     (sd_v),
    .field     (sd_field),
    .line_end  (line_end),
    .field_end (field_end)
  );

  // Serial frequency receiver
  logic                 rx_valid;
  logic [FREQ_BITS-1:0] rx_word;

  tvr_lock_rx #(
    .FRAME_BITS (FRAME_BITS),
    .VAL_BITS   (FREQ_BITS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enable     (is_lock),
    .pin_level  (pin_level),
    .pin_rise   (pin_rise),
    .word_valid (rx_valid),
    .word       (rx_word)
  );

  assign lock_apply = is_lock && line_end && (lock_pend_q || rx_valid);

  // HD counters
  tvr_hd_counters #(
    .H_TOTAL (HD_H_TOTAL),
    .V_TOTAL (HD_V_TOTAL)
  ) u_hd (
    .clk   (clk),
    .rst_n (rst_core_n),
    .hold  (hd_hold),
    .h_cnt (hd_h),
    .v_cnt (hd_v)
  );

  // Phase and frequency state
  logic [PHASE_W-1:0] phase_q, phase_n;
  logic [PHASE_W-1:0] freq_q, freq_n;
  logic               phase_clr;

  assign phase_clr = tr_release || scr_clear;

  always_comb begin
    tr_hold_n   = is_tr  ? ((tr_hold_q || pin_rise) && !pin_fall) : 1'b0;
    scr_pend_n  = is_scr ? ((scr_pend_q && !field_end) || pin_rise) : 1'b0;
    lock_pend_n = is_lock ? ((lock_pend_q || rx_valid) && !line_end) : 1'b0;

    phase_n = phase_clr ? '0 : phase_q + freq_q;

    freq_n = freq_q;
    if (!is_lock) begin
      freq_n = cfg_freq;
    end else if (lock_apply) begin
      freq_n = {{PAD_W{1'b0}}, rx_word};
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tr_hold_q   <= 1'b0;
      scr_pend_q  <= 1'b0;
      lock_pend_q <= 1'b0;
      phase_q     <= '0;
      freq_q      <= '0;
    end else begin
      tr_hold_q   <= tr_hold_n;
      scr_pend_q  <= scr_pend_n;
      lock_pend_q <= lock_pend_n;
      phase_q     <= phase_n;
      freq_q      <= freq_n;
    end
  end

  assign sc_phase = phase_q;
  assign sc_freq  = freq_q;

  // Ignore mode: accumulator keeps plain stepping
  assert_ignore_steps_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode == SYNC_IGNORE) |=> (sc_phase == $past(sc_phase) + $past(sc_freq)));

  assert_tr_held_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (is_tr && tr_hold_q) |=> (sd_h == '0 && sd_v == '0 && sd_field == '0));

  assert_tr_restart_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    tr_release |=> (sc_phase == '0 && sd_h == '0 && sd_field == '0));

  assert_scr_at_field_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    scr_clear |=> (sc_phase == '0 && sd_h == '0 && sd_v == '0));

  assert_cfg_follow_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!is_lock) |=> (sc_freq == $past(cfg_freq)));

  assert_freq_line_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (($past(mode) == SYNC_FREQ_LOCK) && !$stable(sc_freq)) |-> (sd_h == '0));

endmodule

// File: tb/sim_video_sync_ctrl.sv
module sim_video_sync_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int H_TOTAL    = 32;
  localparam int V_TOTAL    = 4;
  localparam int FIELD_LEN  = H_TOTAL * V_TOTAL;
  localparam logic [31:0] F_CFG = 32'h0123_4567;

  // Lock-mode vectors: bit 22 = filler for data bits 22..66, bits 21:0 = value;
  // expected sc_freq is the value zero-extended.
  localparam logic [22:0] LOCK_VEC [4] = '{
    {1'b1, 22'h3A_BCDE},
    {1'b0, 22'h00_0001},
    {1'b1, 22'h2A_AAAA},
    {1'b0, 22'h15_5555}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  sync_mode;
  logic        pal_mode;
  logic        sync_pin;
  logic        hd_hold;
  logic [31:0] cfg_freq;
  logic [4:0]  sd_h;
  logic [1:0]  sd_v;
  logic [2:0]  sd_field;
  logic [31:0] sc_phase;
  logic [31:0] sc_freq;
  logic [5:0]  hd_h;
  logic [2:0]  hd_v;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  video_sync_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .pal_mode  (pal_mode),
    .sync_pin  (sync_pin),
    .hd_hold   (hd_hold),
    .cfg_freq  (cfg_freq),
    .sd_h      (sd_h),
    .sd_v      (sd_v),
    .sd_field  (sd_field),
    .sc_phase  (sc_phase),
    .sc_freq   (sc_freq),
    .hd_h      (hd_h),
    .hd_v      (hd_v)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_for(input int h, input int v, input int limit);
    for (int i = 0; i < limit; i++) begin
      if ((h < 0 || int'(sd_h) == h) && (v < 0 || int'(sd_v) == v)) return;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [21:0] val, input logic fill);
    @(negedge clk); sync_pin = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 67; b++) begin
      @(negedge clk); sync_pin = (b < 22) ? val[b] : fill;
      @(negedge clk);
    end
    @(negedge clk); sync_pin = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p0, p1, prev_f;
    int h0, f0;
    bit seen;

    rst_n = 1'b0; sync_mode = 2'b00; pal_mode = 1'b0;
    sync_pin = 1'b0; hd_hold = 1'b0; cfg_freq = F_CFG;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sd_h == 0 && sd_v == 0, "R1 raster zero", {sd_v, sd_h}, 0);
    check(sd_field == 0, "R1 field zero", sd_field, 0);
    check(sc_phase == 0, "R1 phase zero", sc_phase, 0);
    check(sc_freq == 0, "R1 freq zero", sc_freq, 0);
    check(hd_h == 0 && hd_v == 0, "R1 hd zero", {hd_v, hd_h}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: pixel wrap and line advance
    wait_for(H_TOTAL - 1, -1, 64);
    h0 = int'(sd_v);
    @(negedge clk);
    check(sd_h == 0, "R2 pixel wrap", sd_h, 0);
    check(int'(sd_v) == (h0 + 1) % V_TOTAL, "R2 line advance", sd_v, (h0 + 1) % V_TOTAL);

    // R3: four-field sequence
    for (int k = 0; k < 5; k++) begin
      wait_for(H_TOTAL - 1, V_TOTAL - 1, 300);
      f0 = int'(sd_field);
      @(negedge clk);
      check(int'(sd_field) == (f0 + 1) % 4, "R3 ntsc field", sd_field, (f0 + 1) % 4);
    end
    // R3: eight-field sequence
    pal_mode = 1'b1;
    for (int k = 0; k < 9; k++) begin
      wait_for(H_TOTAL - 1, V_TOTAL - 1, 300);
      f0 = int'(sd_field);
      @(negedge clk);
      check(int'(sd_field) == (f0 + 1) % 8, "R3 pal field", sd_field, (f0 + 1) % 8);
    end

    // R8: one-step accumulate
    p0 = sc_phase;
    @(negedge clk);
    check(sc_phase == p0 + F_CFG, "R8 phase step", sc_phase, p0 + F_CFG);

    // R4: pin ignored in mode 00
    h0 = int'(sd_h); p0 = sc_phase;
    sync_pin = 1'b1;
    repeat (4) @(negedge clk);
    sync_pin = 1'b0;
    repeat (8) @(negedge clk);
    check(int'(sd_h) == (h0 + 12) % H_TOTAL, "R4 pixel unaffected", sd_h, (h0 + 12) % H_TOTAL);
    check(sc_phase == p0 + F_CFG * 32'd12, "R4 phase unaffected", sc_phase, p0 + F_CFG * 32'd12);

    // R5: timing reset hold
    sync_mode = 2'b10;
    repeat (3) @(negedge clk);
    sync_pin = 1'b1;
    repeat (20) @(negedge clk);
    check(sd_h == 0 && sd_v == 0, "R5 raster held", {sd_v, sd_h}, 0);
    check(sd_field == 0, "R5 field held", sd_field, 0);
    repeat (40) @(negedge clk);
    check(sd_h == 0 && sd_v == 0 && sd_field == 0, "R5 held past a line", {sd_field, sd_v, sd_h}, 0);

    // R6: release restarts and clears phase
    sync_pin = 1'b0;
    repeat (3) @(negedge clk);
    check(sd_h == 0 && sd_field == 0, "R6 restart point", {sd_field, sd_h}, 0);
    check(sc_phase == 0, "R6 phase cleared", sc_phase, 0);
    repeat (5) @(negedge clk);
    check(sd_h == 5, "R6 counting resumed", sd_h, 5);
    check(sc_phase == F_CFG * 32'd5, "R6 phase resumed", sc_phase, F_CFG * 32'd5);

    // R7: phase reset at next field start
    sync_mode = 2'b01;
    wait_for(0, 1, 300);
    f0 = int'(sd_field);
    sync_pin = 1'b1;
    repeat (2) @(negedge clk);
    sync_pin = 1'b0;
    @(negedge clk);
    wait_for(0, 0, 300);
    check(sc_phase == 0, "R7 phase zero at field start", sc_phase, 0);
    check(int'(sd_field) == (f0 + 1) % 8, "R7 field not reset", sd_field, (f0 + 1) % 8);
    @(negedge clk);
    wait_for(0, 0, 300);
    check(sc_phase == F_CFG * 32'(FIELD_LEN), "R7 single clear", sc_phase, F_CFG * 32'(FIELD_LEN));

    // R9, R10, R11: frequency lock
    sync_mode = 2'b11;
    repeat (4) @(negedge clk);
    check(sc_freq == F_CFG, "R9 lock starts from cfg", sc_freq, F_CFG);
    prev_f = sc_freq;
    for (int n = 0; n < 4; n++) begin
      send_frame(LOCK_VEC[n][21:0], LOCK_VEC[n][22]);
      seen = 1'b0;
      for (int i = 0; i < 300 && !seen; i++) begin
        @(negedge clk);
        if (sc_freq != prev_f) seen = 1'b1;
      end
      check(seen, "R10 frame applied", {63'd0, seen}, 1);
      check(sc_freq == {10'd0, LOCK_VEC[n][21:0]}, "R10 frame value", sc_freq, {10'd0, LOCK_VEC[n][21:0]});
      check(sd_h == 0, "R11 applied at line start", sd_h, 0);
      p0 = sc_phase;
      @(negedge clk);
      p1 = sc_phase;
      check(p1 - p0 == sc_freq, "R8 step with locked freq", p1 - p0, sc_freq);
      prev_f = sc_freq;
      repeat (3) @(negedge clk);
    end
    sync_mode = 2'b00;
    repeat (2) @(negedge clk);
    check(sc_freq == F_CFG, "R9 back to cfg", sc_freq, F_CFG);

    // R12: HD hold
    hd_hold = 1'b1;
    h0 = int'(sd_h);
    repeat (10) @(negedge clk);
    check(hd_h == 0 && hd_v == 0, "R12 hd held", {hd_v, hd_h}, 0);
    check(int'(sd_h) == (h0 + 10) % H_TOTAL, "R12 sd unaffected", sd_h, (h0 + 10) % H_TOTAL);
    hd_hold = 1'b0;
    @(negedge clk);
    check(hd_h == 1, "R12 hd resumes", hd_h, 1);
    repeat (4) @(negedge clk);
    check(hd_h == 5 && hd_v == 0, "R12 hd counting", {hd_v, hd_h}, 5);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule